// File: doc/BRIEF.md
# Dual-Plane Flash Status Read Multiplexer

This block forms the byte returned by a read of a two-plane flash array while internal program and erase operations run. The sequencer elsewhere in the chip reports what each plane is doing. The block then chooses, for every read, between the true array byte and a status byte.

The status byte carries three progress indicators:
- a data-polling bit on bit 7;
- a toggle bit on bit 6 that flips on every read of a busy plane;
- a second toggle on bit 2 that marks the sector whose erase is on hold.

Reads that land in the plane that is not busy pass array data through untouched, so code can keep running from one plane while the other is being written. The block also drives the pull-down enable of an open-drain ready/busy line.

The plane is selected by the most significant read-address bit. The sector is the top `SECT_W` address bits, and this includes the plane bit. Each plane reports a 3-bit mode:

| Code | Mode |
|------|------|
| 0 | idle |
| 1 | programming |
| 2 | erasing |
| 3 | erase suspended |
| 4 | programming while an erase is suspended |

Each plane keeps its own pair of toggle flops.

Top module: `flash_status_mux`

## Requirements
- R1: A read whose addressed plane is in mode 0 returns `array_data` unchanged, whatever the other plane is doing.
- R2: A read of a plane in mode 1 returns the following byte:
  - bit 7 is the inverse of `prog_data_msb` when `rd_addr` equals `prog_addr`, and the array bit 7 otherwise;
  - bit 6 is the plane's main toggle;
  - bit 2 is 1;
  - bits 5:3 and 1:0 are array data.
- R3: A read of a plane in mode 2 returns the following byte:
  - bit 7 is 0;
  - bit 6 is the main toggle;
  - bit 2 is the suspend toggle;
  - bits 5:3 and 1:0 are array data.
- R4: The main toggle reads 0 first after reset. It flips after each read of its plane in mode 1, 2 or 4, and holds in modes 0 and 3. The two planes keep independent toggles.
- R5: In mode 3, a read of the sector equal to `susp_sector` returns the following byte:
  - bits 7 and 6 are 1;
  - bit 2 is the suspend toggle, which then flips;
  - bits 5:3 and 1:0 are array data.
  
  Reads of other sectors in that plane return array data and leave both toggles unchanged.
- R6: In mode 4, a read of the `susp_sector` sector returns the following byte, after which both toggles flip:
  - bit 7 is 1;
  - bit 6 is the main toggle;
  - bit 2 is the suspend toggle.
  
  Other addresses read as in R2, and only the main toggle flips.
- R7: `rb_pull_low` is 1 on the clock after any plane is in mode 1, 2 or 4. It is 0 on the clock after both planes are in mode 0 or 3.
- R8: A read is taken on the clock where `rd_stb` is first seen high. `rd_data` loads that value and holds it until the next such clock. Holding `rd_stb` high counts as a single read.
- R9: Synchronous reset clears `rd_data`, `rb_pull_low` and all four toggles to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | ADDR_W | Read address; MSB selects the plane |
| rd_stb | input | 1 | Read strobe; rising edge takes a read |
| pl0_mode | input | 3 | Plane 0 operating mode |
| pl1_mode | input | 3 | Plane 1 operating mode |
| susp_sector | input | SECT_W | Sector whose erase is suspended |
| prog_addr | input | ADDR_W | Address of the word being programmed |
| prog_data_msb | input | 1 | Bit 7 of the data being programmed |
| array_data | input | 8 | Array byte at `rd_addr` |
| rd_data | output | 8 | Returned data or status byte |
| rb_pull_low | output | 1 | Enables the open-drain pull-down of ready/busy |

## Verification
Every pairing of the two plane modes is applied in turn. Each pairing is read at six addresses spread over both planes, and each address is read twice in a row. This covers the programmed address, another word in the same sector, the suspended sector and a foreign plane.

The back-to-back reads separate a real toggle from a stuck bit. The split between addresses separates plane selection, sector matching and programmed-address matching from one another. A held strobe checks that one strobe counts as one read. A mid-run reset checks that the toggles start again from 0.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE      = 3'd0,
        MODE_PROG      = 3'd1,
        MODE_ERASE     = 3'd2,
        MODE_SUSP      = 3'd3,
        MODE_SUSP_PROG = 3'd4
    } plane_mode_e;

    typedef struct packed {
        logic main_tog;
        logic susp_tog;
    } toggle_t;

    typedef struct packed {
        logic        hit_susp;
        logic        at_prog;
        logic        prog_msb;
        logic [7:0]  arr;
    } read_ctx_t;

    function automatic plane_mode_e decode_mode(input logic [2:0] raw);
        plane_mode_e m;
        case (raw)
            3'd1:    m = MODE_PROG;
            3'd2:    m = MODE_ERASE;
            3'd3:    m = MODE_SUSP;
            3'd4:    m = MODE_SUSP_PROG;
            default: m = MODE_IDLE;
        endcase
        return m;
    endfunction

    function automatic logic mode_busy(input plane_mode_e m);
        return (m == MODE_PROG) || (m == MODE_ERASE) || (m == MODE_SUSP_PROG);
    endfunction

    function automatic logic main_advances(input plane_mode_e m);
        return mode_busy(m);
    endfunction

    function automatic logic susp_advances(input plane_mode_e m, input logic hit_susp);
        return (m == MODE_ERASE) ||
               (((m == MODE_SUSP) || (m == MODE_SUSP_PROG)) && hit_susp);
    endfunction

endpackage

// File: rtl/plane_tracker.sv
module plane_tracker
    import flash_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        read_evt,
    input  plane_mode_e mode,
    input  logic        hit_susp,
    output toggle_t     tog
);

    toggle_t tog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q <= '0;
        end else if (read_evt) begin
            if (main_advances(mode)) begin
                tog_q.main_tog <= ~tog_q.main_tog;
            end
            if (susp_advances(mode, hit_susp)) begin
                tog_q.susp_tog <= ~tog_q.susp_tog;
            end
        end
    end

    assign tog = tog_q;

endmodule

// File: rtl/status_compose.sv
module status_compose
    import flash_stat_pkg::*;
(
    input  plane_mode_e mode,
    input  toggle_t     tog,
    input  read_ctx_t   ctx,
    output logic [7:0]  value
);

    logic       poll_bit;
    logic [7:0] prog_view;
    logic [7:0] erase_view;
    logic [7:0] susp_view;
    logic [7:0] susp_prog_view;

    always_comb begin
        poll_bit  = ctx.at_prog ? ~ctx.prog_msb : ctx.arr[7];

        prog_view = {poll_bit, tog.main_tog, ctx.arr[5:3], 1'b1, ctx.arr[1:0]};

        erase_view = {1'b0, tog.main_tog, ctx.arr[5:3], tog.susp_tog, ctx.arr[1:0]};

        susp_view = ctx.hit_susp
                  ? {1'b1, 1'b1, ctx.arr[5:3], tog.susp_tog, ctx.arr[1:0]}
                  : ctx.arr;

        susp_prog_view = ctx.hit_susp
                       ? {1'b1, tog.main_tog, ctx.arr[5:3], tog.susp_tog, ctx.arr[1:0]}
                       : prog_view;

        case (mode)
            MODE_PROG:      value = prog_view;
            MODE_ERASE:     value = erase_view;
            MODE_SUSP:      value = susp_view;
            MODE_SUSP_PROG: value = susp_prog_view;
            default:        value = ctx.arr;
        endcase
    end

endmodule

// File: rtl/busy_driver.sv
module busy_driver #(
    parameter int N_PLANES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_PLANES-1:0] plane_busy,
    output logic                pull_low
);

    logic pull_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pull_q <= 1'b0;
        end else begin
            pull_q <= |plane_busy;
        end
    end

    assign pull_low = pull_q;

endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
    import flash_stat_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_stb,
    input  logic [2:0]        pl0_mode,
    input  logic [2:0]        pl1_mode,
    input  logic [SECT_W-1:0] susp_sector,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic              prog_data_msb,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data,
    output logic              rb_pull_low
);

    localparam int N_PLANES = 2;
    localparam int PLANE_MSB = ADDR_W - 1;
    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic        stb_q;
    logic        stb_rise;
    logic        rd_plane;
    logic        hit_susp;
    plane_mode_e modes      [N_PLANES];
    toggle_t     togs       [N_PLANES];
    logic [N_PLANES-1:0] plane_busy;
    plane_mode_e sel_mode;
    toggle_t     sel_tog;
    read_ctx_t   ctx;
    logic [7:0]  next_value;
    logic [7:0]  rd_data_q;

    assign modes[0] = decode_mode(pl0_mode);
    assign modes[1] = decode_mode(pl1_mode);

    assign stb_rise = rd_stb & ~stb_q;
    assign rd_plane = rd_addr[PLANE_MSB];
    assign hit_susp = (rd_addr[ADDR_W-1:SECT_LSB] == susp_sector);

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= rd_stb;
        end
    end

    for (genvar p = 0; p < N_PLANES; p++) begin : g_plane
        logic hit_plane;
        assign hit_plane     = (rd_plane == p[0]);
        assign plane_busy[p] = mode_busy(modes[p]);

        plane_tracker u_trk (
            .clk      (clk),
            .rst      (rst),
            .read_evt (stb_rise & hit_plane),
            .mode     (modes[p]),
            .hit_susp (hit_susp),
            .tog      (togs[p])
        );
    end

    assign sel_mode = modes[rd_plane];
    assign sel_tog  = togs[rd_plane];

    always_comb begin
        ctx.hit_susp = hit_susp;
        ctx.at_prog  = (rd_addr == prog_addr);
        ctx.prog_msb = prog_data_msb;
        ctx.arr      = array_data;
    end

    status_compose u_compose (
        .mode  (sel_mode),
        .tog   (sel_tog),
        .ctx   (ctx),
        .value (next_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else if (stb_rise) begin
            rd_data_q <= next_value;
        end
    end

    assign rd_data = rd_data_q;

    busy_driver #(.N_PLANES(N_PLANES)) u_busy (
        .clk        (clk),
        .rst        (rst),
        .plane_busy (plane_busy),
        .pull_low   (rb_pull_low)
    );

endmodule

// File: rtl/flash_status_mux_chk.sv
module flash_status_mux_chk #(
    parameter int ADDR_W = 12,
    parameter int SECT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_stb,
    input logic              stb_q,
    input logic [2:0]        pl0_mode,
    input logic [2:0]        pl1_mode,
    input logic [SECT_W-1:0] susp_sector,
    input logic [ADDR_W-1:0] prog_addr,
    input logic              prog_data_msb,
    input logic [7:0]        array_data,
    input logic [7:0]        rd_data,
    input logic              rb_pull_low
);

    logic       rise;
    logic [2:0] amode;
    logic       hit;
    logic       any_busy;

    assign rise  = rd_stb && !stb_q;
    assign amode = rd_addr[ADDR_W-1] ? pl1_mode : pl0_mode;
    assign hit   = (rd_addr[ADDR_W-1:ADDR_W-SECT_W] == susp_sector);
    assign any_busy = (pl0_mode == 3'd1) || (pl0_mode == 3'd2) || (pl0_mode == 3'd4) ||
                      (pl1_mode == 3'd1) || (pl1_mode == 3'd2) || (pl1_mode == 3'd4);

    p_idle_passthru_r1: assert property (@(posedge clk) disable iff (rst)
        (rise && amode == 3'd0) |=> (rd_data == $past(array_data)));

    p_poll_bit7_r2: assert property (@(posedge clk) disable iff (rst)
        (rise && amode == 3'd1 && rd_addr == prog_addr) |=> (rd_data[7] == !$past(prog_data_msb)));

    p_erase_bit7_r3: assert property (@(posedge clk) disable iff (rst)
        (rise && amode == 3'd2) |=> (rd_data[7] == 1'b0));

    p_susp_sector_r5: assert property (@(posedge clk) disable iff (rst)
        (rise && amode == 3'd3 && hit) |=> (rd_data[7] && rd_data[6]));

    p_busy_set_r7: assert property (@(posedge clk) disable iff (rst)
        any_busy |=> rb_pull_low);

    p_busy_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !any_busy |=> !rb_pull_low);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(rd_data));

endmodule

bind flash_status_mux flash_status_mux_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_addr       (rd_addr),
    .rd_stb        (rd_stb),
    .stb_q         (stb_q),
    .pl0_mode      (pl0_mode),
    .pl1_mode      (pl1_mode),
    .susp_sector   (susp_sector),
    .prog_addr     (prog_addr),
    .prog_data_msb (prog_data_msb),
    .array_data    (array_data),
    .rd_data       (rd_data),
    .rb_pull_low   (rb_pull_low)
);

// File: tb/test_flash_status_mux.sv
module test_flash_status_mux;

    localparam int AW = 12;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_stb = 1'b0;
    logic [2:0]    pl0_mode = 3'd0;
    logic [2:0]    pl1_mode = 3'd0;
    logic [SW-1:0] susp_sector = '0;
    logic [AW-1:0] prog_addr = '0;
    logic          prog_data_msb = 1'b0;
    logic [7:0]    array_data;
    logic [7:0]    rd_data;
    logic          rb_pull_low;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    bit e_main [2];
    bit e_susp [2];

    always #10 clk = ~clk;

    function automatic logic [7:0] mem(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    assign array_data = mem(rd_addr);

    flash_status_mux #(.ADDR_W(AW), .SECT_W(SW)) i_flash_status_mux (
        .clk           (clk),
        .rst           (rst),
        .rd_addr       (rd_addr),
        .rd_stb        (rd_stb),
        .pl0_mode      (pl0_mode),
        .pl1_mode      (pl1_mode),
        .susp_sector   (susp_sector),
        .prog_addr     (prog_addr),
        .prog_data_msb (prog_data_msb),
        .array_data    (array_data),
        .rd_data       (rd_data),
        .rb_pull_low   (rb_pull_low)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Expected read value from the requirements; advances the model toggles.
    function automatic logic [7:0] predict(input logic [AW-1:0] a, output string req);
        int         pl;
        logic [2:0] m;
        logic       hit;
        logic       at;
        logic [7:0] arr;
        logic [7:0] v;
        logic       pb;
        pl  = a[AW-1] ? 1 : 0;
        m   = pl ? pl1_mode : pl0_mode;
        hit = (a[AW-1:AW-SW] == susp_sector);
        at  = (a == prog_addr);
        arr = mem(a);
        pb  = at ? ~prog_data_msb : arr[7];
        v   = arr;
        req = "R1";
        case (m)
            3'd1: begin
                v = {pb, e_main[pl], arr[5:3], 1'b1, arr[1:0]};
                e_main[pl] = ~e_main[pl];
                req = "R2/R4";
            end
            3'd2: begin
                v = {1'b0, e_main[pl], arr[5:3], e_susp[pl], arr[1:0]};
                e_main[pl] = ~e_main[pl];
                e_susp[pl] = ~e_susp[pl];
                req = "R3/R4";
            end
            3'd3: begin
                req = "R5";
                if (hit) begin
                    v = {1'b1, 1'b1, arr[5:3], e_susp[pl], arr[1:0]};
                    e_susp[pl] = ~e_susp[pl];
                end
            end
            3'd4: begin
                req = "R6";
                if (hit) begin
                    v = {1'b1, e_main[pl], arr[5:3], e_susp[pl], arr[1:0]};
                    e_susp[pl] = ~e_susp[pl];
                end else begin
                    v = {pb, e_main[pl], arr[5:3], 1'b1, arr[1:0]};
                end
                e_main[pl] = ~e_main[pl];
            end
            default: ;
        endcase
        return v;
    endfunction

    task automatic do_read(input logic [AW-1:0] a, input int hold);
        logic [7:0] exp;
        string      req;
        @(negedge clk);
        rd_addr = a;
        rd_stb  = 1'b1;
        exp = predict(a, req);
        @(negedge clk);
        check(req, rd_data, exp);
        for (int h = 1; h < hold; h++) begin
            @(negedge clk);
            check("R8", rd_data, exp);
        end
        rd_stb = 1'b0;
        @(negedge clk);
        check("R8", rd_data, exp);
    endtask

    function automatic bit is_busy(input logic [2:0] m);
        return (m == 3'd1) || (m == 3'd2) || (m == 3'd4);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < 2; p++) begin
            e_main[p] = 1'b0;
            e_susp[p] = 1'b0;
        end
        check("R9", rd_data, 8'h00);
        check("R9", {7'd0, rb_pull_low}, 8'h00);
    endtask

    initial begin
        logic [AW-1:0] addrs [6];
        addrs[0] = 12'h233;
        addrs[1] = 12'h205;
        addrs[2] = 12'h0F0;
        addrs[3] = 12'h933;
        addrs[4] = 12'h905;
        addrs[5] = 12'hA10;

        pl0_mode = 3'd2;
        pl1_mode = 3'd1;
        do_reset();

        for (int m0 = 0; m0 < 5; m0++) begin
            for (int m1 = 0; m1 < 5; m1++) begin
                @(negedge clk);
                pl0_mode      = m0[2:0];
                pl1_mode      = m1[2:0];
                susp_sector   = (m1 >= 3) ? 4'h9 : 4'h2;
                prog_addr     = ((m1 == 1) || (m1 == 4)) ? 12'h933 : 12'h233;
                prog_data_msb = m0[0] ^ m1[0];
                @(negedge clk);
                check("R7", {7'd0, rb_pull_low},
                      {7'd0, is_busy(m0[2:0]) || is_busy(m1[2:0])});
                for (int i = 0; i < 6; i++) begin
                    do_read(addrs[i], 1);
                    do_read(addrs[i], 1);
                end
            end
        end

        // R8: strobe held high for several clocks is one read
        @(negedge clk);
        pl0_mode = 3'd2;
        pl1_mode = 3'd0;
        do_read(12'h010, 4);
        do_read(12'h010, 1);

        // R9: reset mid-run restarts toggles at 0
        do_reset();
        do_read(12'h011, 1);
        do_read(12'h011, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule